// File: doc/BRIEF.md
# Command/Response FIFO Engine

This block carries one command from a host to an execution backend and carries the response back. It has a single shared byte buffer and exactly one data register. The host first sends a command-ready request. It then writes the command into the data register one byte at a time. The engine reads the command length out of the header as the bytes arrive. A status bit tells the host whether more bytes are still awaited. A go request passes the whole command to the backend with a simple request/done handshake.

The backend writes its response into the same buffer and then signals done. The host reads the response back one byte at a time through the data register. The status byte also provides:

- a retry request, which replays the response from its first byte;
- an abort path, used when command-ready is written while a command is being received or executed.

A burst count tells the host how many bytes it may move in a row. It exists in two forms: a saturating one-byte view and a full-width view split across two byte addresses.

Top module: `cmd_fifo_engine`

## Requirements
- R1: After reset the engine is idle. The status byte (address 0) holds the FAMILY parameter in bits 1:0 and every flag is clear. The flag positions are bit 7 valid, bit 6 command-ready, bit 4 data-available, bit 3 expect and bit 2 self-test-done. The wide burst count (address 2 low byte, address 3 high byte) reads DEPTH.
- R2: Writing 0x40 to address 0 while idle moves the engine to ready, sets command-ready and pulses ev_cmd_ready for one cycle. The same write while already ready changes nothing and raises no event.
- R3: The first data write (address 4) while ready moves the engine to reception and makes the status valid plus expect. Data writes while idle, executing or completed are dropped: the burst count and status stay as they were.
- R4: The command length is the 32-bit big-endian value held in buffer bytes 2 to 5. Expect stays set for the first five bytes. From the sixth byte on, expect stays set while the length exceeds the byte count and clears once the count reaches it.
- R5: Data bytes written during reception after expect has cleared are not counted and not stored.
- R6: A byte that arrives when DEPTH bytes are already held is not stored and clears expect.
- R7: Writing 0x20 to address 0 during reception with expect clear starts execution and pulses be_req for one cycle, with be_len equal to the received byte count. With expect still set, the write is ignored.
- R8: be_done during execution moves the engine to completion. It leaves only valid and data-available set, on top of the sticky bits, and pulses ev_valid and ev_data_avail. If be_selftest is high with be_done, self-test-done is set and no later status update clears it before reset.
- R9: In completion, each data read returns the next response byte, starting at buffer index 0, on acc_rdata in the cycle after the read. After the last byte of min(length, DEPTH), data-available clears and ev_valid pulses. A data read with no data available returns 0xFF.
- R10: Writing 0x02 to address 0 in completion rewinds the response to byte 0 and sets valid and data-available again.
- R11: The burst count is the number of unread response bytes while data-available is set, and DEPTH minus the byte count otherwise. The one-byte view at address 1 saturates at 0xFF.
- R12: Writing 0x40 in completion moves the engine to ready, clears data-available and sets command-ready with an ev_cmd_ready pulse.
- R13: Writing 0x40 during reception returns the engine to ready at once, with command-ready set, an event pulse and a byte count of 0. Writing 0x40 during execution pulses be_cancel and keeps executing until be_done; be_done then moves the engine to ready with command-ready and the event, and leaves data-available clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_wr | input | 1 | Host write strobe |
| acc_rd | input | 1 | Host read strobe (ignored while acc_wr is high) |
| acc_addr | input | 3 | 0 status, 1 burst byte view, 2/3 burst wide low/high, 4 data |
| acc_wdata | input | 8 | Host write data |
| acc_rdata | output | 8 | Read data, registered |
| ev_cmd_ready | output | 1 | Command-ready event pulse |
| ev_valid | output | 1 | Valid event pulse |
| ev_data_avail | output | 1 | Data-available event pulse |
| be_req | output | 1 | Command handed to backend (pulse) |
| be_cancel | output | 1 | Cancel request to backend (pulse) |
| be_len | output | $clog2(DEPTH+1) | Command length passed with be_req |
| be_wr | input | 1 | Backend response byte write |
| be_addr | input | $clog2(DEPTH) | Backend response byte index |
| be_wdata | input | 8 | Backend response byte |
| be_done | input | 1 | Backend completion |
| be_selftest | input | 1 | Self-test finished, sampled with be_done |

## Verification
Every host access and every backend done takes effect at the clock edge that samples it. A read's data, each event pulse, be_req and be_cancel are all visible for exactly the following cycle. A status or burst read issued in the next access therefore already sees the new state. The bench drives each access on a falling edge and samples results on the next falling edge, one cycle after the sampling edge. Pulse outputs are captured in that window and checked to be low after accesses that must not raise them.

// File: rtl/cmd_fifo_engine.sv
module cmd_fifo_engine #(
  parameter int DEPTH = 4096,
  parameter logic [1:0] FAMILY = 2'b01
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_wr,
  input  logic                       acc_rd,
  input  logic [2:0]                 acc_addr,
  input  logic [7:0]                 acc_wdata,
  output logic [7:0]                 acc_rdata,
  output logic                       ev_cmd_ready,
  output logic                       ev_valid,
  output logic                       ev_data_avail,
  output logic                       be_req,
  output logic                       be_cancel,
  output logic [$clog2(DEPTH+1)-1:0] be_len,
  input  logic                       be_wr,
  input  logic [$clog2(DEPTH)-1:0]   be_addr,
  input  logic [7:0]                 be_wdata,
  input  logic                       be_done,
  input  logic                       be_selftest
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_READY, S_RX, S_EXEC, S_DONE} state_t;

  state_t        st;
  logic          f_valid, f_cmdrdy, f_davail, f_expect, selftest, abort_pend;
  logic [PW-1:0] ptr, ptr_inc, rlen, remain, burst;
  logic [31:0]   hdr_len, hdr_nx;
  logic [15:0]   burst16;
  logic [7:0]    burst8, cmd_bits, sts_byte, mem_wd;
  logic [AW-1:0] mem_wa;
  logic          wr_sts, wr_dat, rd_any, host_store, be_store, mem_we;
  logic [7:0]    mem [DEPTH];

  assign wr_sts   = acc_wr && acc_addr == 3'd0;
  assign wr_dat   = acc_wr && acc_addr == 3'd4;
  assign rd_any   = acc_rd && !acc_wr;
  assign cmd_bits = acc_wdata & 8'h62;
  assign ptr_inc  = ptr + 1'b1;

  assign host_store = wr_dat && ptr < DEPTH_P &&
                      (st == S_READY || (st == S_RX && f_expect));
  assign be_store   = be_wr && st == S_EXEC;
  assign mem_we     = host_store || be_store;
  assign mem_wa     = host_store ? ptr[AW-1:0] : be_addr;
  assign mem_wd     = host_store ? acc_wdata : be_wdata;

  always_comb begin
    hdr_nx = hdr_len;
    if (mem_we)
      case (mem_wa)
        AW'(2): hdr_nx[31:24] = mem_wd;
        AW'(3): hdr_nx[23:16] = mem_wd;
        AW'(4): hdr_nx[15:8]  = mem_wd;
        AW'(5): hdr_nx[7:0]   = mem_wd;
        default: ;
      endcase
  end

  assign rlen     = (hdr_len > 32'(DEPTH)) ? DEPTH_P : hdr_len[PW-1:0];
  assign remain   = (ptr < rlen) ? rlen - ptr : '0;
  assign burst    = f_davail ? remain : DEPTH_P - ptr;
  assign burst16  = 16'(burst);
  assign burst8   = (burst16 > 16'd255) ? 8'hFF : burst16[7:0];
  assign sts_byte = {f_valid, f_cmdrdy, 1'b0, f_davail, f_expect, selftest, FAMILY};

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      f_valid       <= 1'b0;
      f_cmdrdy      <= 1'b0;
      f_davail      <= 1'b0;
      f_expect      <= 1'b0;
      selftest      <= 1'b0;
      abort_pend    <= 1'b0;
      ptr           <= '0;
      hdr_len       <= '0;
      acc_rdata     <= '0;
      ev_cmd_ready  <= 1'b0;
      ev_valid      <= 1'b0;
      ev_data_avail <= 1'b0;
      be_req        <= 1'b0;
      be_cancel     <= 1'b0;
      be_len        <= '0;
    end else begin
      ev_cmd_ready  <= 1'b0;
      ev_valid      <= 1'b0;
      ev_data_avail <= 1'b0;
      be_req        <= 1'b0;
      be_cancel     <= 1'b0;
      if (mem_we) hdr_len <= hdr_nx;

      if (be_done && st == S_EXEC) begin
        if (be_selftest) selftest <= 1'b1;
        ptr      <= '0;
        f_expect <= 1'b0;
        if (abort_pend) begin
          st           <= S_READY;
          abort_pend   <= 1'b0;
          f_valid      <= 1'b0;
          f_cmdrdy     <= 1'b1;
          f_davail     <= 1'b0;
          ev_cmd_ready <= 1'b1;
        end else begin
          st            <= S_DONE;
          f_valid       <= 1'b1;
          f_cmdrdy      <= 1'b0;
          f_davail      <= 1'b1;
          ev_valid      <= 1'b1;
          ev_data_avail <= 1'b1;
        end
      end else if (wr_sts) begin
        if (cmd_bits == 8'h40) begin
          case (st)
            S_IDLE, S_RX: begin
              st           <= S_READY;
              {f_valid, f_cmdrdy, f_davail, f_expect} <= 4'b0100;
              ptr          <= '0;
              ev_cmd_ready <= 1'b1;
            end
            S_EXEC: begin
              be_cancel  <= 1'b1;
              abort_pend <= 1'b1;
            end
            S_DONE: begin
              st       <= S_READY;
              ptr      <= '0;
              f_davail <= 1'b0;
              if (!f_cmdrdy) begin
                f_valid      <= 1'b0;
                f_cmdrdy     <= 1'b1;
                f_expect     <= 1'b0;
                ev_cmd_ready <= 1'b1;
              end
            end
            default: ;
          endcase
        end else if (cmd_bits == 8'h20) begin
          if (st == S_RX && !f_expect) begin
            st     <= S_EXEC;
            be_req <= 1'b1;
            be_len <= ptr;
          end
        end else if (cmd_bits == 8'h02) begin
          if (st == S_DONE) begin
            ptr <= '0;
            {f_valid, f_cmdrdy, f_davail, f_expect} <= 4'b1010;
          end
        end
      end else if (wr_dat) begin
        if (st == S_READY) begin
          st  <= S_RX;
          {f_valid, f_cmdrdy, f_davail, f_expect} <= 4'b1001;
          ptr <= ptr_inc;
        end else if (st == S_RX && f_expect) begin
          if (ptr < DEPTH_P) begin
            ptr <= ptr_inc;
            if (ptr_inc > PW'(5)) begin
              {f_valid, f_cmdrdy, f_davail} <= 3'b100;
              f_expect <= hdr_nx > 32'(ptr_inc);
              if (!f_valid) ev_valid <= 1'b1;
            end
          end else begin
            {f_valid, f_cmdrdy, f_davail, f_expect} <= 4'b1000;
          end
        end
      end else if (rd_any) begin
        case (acc_addr)
          3'd0: acc_rdata <= sts_byte;
          3'd1: acc_rdata <= burst8;
          3'd2: acc_rdata <= burst16[7:0];
          3'd3: acc_rdata <= burst16[15:8];
          3'd4: begin
            if (st == S_DONE && f_davail) begin
              acc_rdata <= mem[ptr[AW-1:0]];
              ptr       <= ptr_inc;
              if (ptr_inc >= rlen) begin
                {f_valid, f_cmdrdy, f_davail, f_expect} <= 4'b1000;
                ev_valid <= 1'b1;
              end
            end else begin
              acc_rdata <= 8'hFF;
            end
          end
          default: acc_rdata <= 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_fifo_engine_chk.sv
module cmd_fifo_engine_chk #(
  parameter int DEPTH = 4096
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 st,
  input logic                       f_expect,
  input logic                       f_davail,
  input logic                       f_cmdrdy,
  input logic                       selftest,
  input logic [$clog2(DEPTH+1)-1:0] ptr,
  input logic                       ev_cmd_ready,
  input logic                       be_req,
  input logic                       be_cancel,
  input logic [$clog2(DEPTH+1)-1:0] be_len
);
  localparam int PW = $clog2(DEPTH + 1);

  assert_expect_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    f_expect |-> st == 3'd2);

  assert_davail_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    f_davail |-> st == 3'd4);

  assert_selftest_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    selftest |=> selftest);

  assert_req_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> (st == 3'd3 && be_len == ptr));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(DEPTH));

  assert_cmdrdy_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_ready |-> (f_cmdrdy && st == 3'd1));

  assert_cancel_exec_R13: assert property (@(posedge clk) disable iff (!rst_n)
    be_cancel |-> st == 3'd3);
endmodule

bind cmd_fifo_engine cmd_fifo_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .f_expect(f_expect), .f_davail(f_davail),
  .f_cmdrdy(f_cmdrdy), .selftest(selftest), .ptr(ptr), .ev_cmd_ready(ev_cmd_ready),
  .be_req(be_req), .be_cancel(be_cancel), .be_len(be_len)
);

// File: tb/test_cmd_fifo_engine.sv
module test_cmd_fifo_engine;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        acc_wr = 0, acc_rd = 0;
  logic [2:0]  acc_addr = 0;
  logic [7:0]  acc_wdata = 0, acc_rdata;
  logic        ev_cmd_ready, ev_valid, ev_data_avail, be_req, be_cancel;
  logic [12:0] be_len;
  logic        be_wr = 0, be_done = 0, be_selftest = 0;
  logic [11:0] be_addr = 0;
  logic [7:0]  be_wdata = 0;

  int nchk = 0, nbad = 0, stk = 0;
  logic [7:0] rq;
  logic e_c, e_v, e_d, e_rq, e_cn;
  logic [7:0] rbuf [DEPTH];

  always #5 clk = ~clk;

  cmd_fifo_engine i_cmd_fifo_engine (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ev_cmd_ready(ev_cmd_ready),
    .ev_valid(ev_valid), .ev_data_avail(ev_data_avail), .be_req(be_req),
    .be_cancel(be_cancel), .be_len(be_len), .be_wr(be_wr), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_done(be_done), .be_selftest(be_selftest)
  );

  function automatic int sts(bit v, bit c, bit d, bit e);
    return {24'd0, v, c, 1'b0, d, e, 1'b0, 2'b01} | stk;
  endfunction

  function automatic int sat(int b);
    return (b > 255) ? 255 : b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic grab;
    e_c = ev_cmd_ready; e_v = ev_valid; e_d = ev_data_avail; e_rq = be_req; e_cn = be_cancel;
  endtask

  task automatic acc(input bit w, input logic [2:0] a, input logic [7:0] d);
    acc_wr = w; acc_rd = !w; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    rq = acc_rdata;
    grab();
    acc_wr = 0; acc_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a);
    acc(1'b0, a, 8'h00);
  endtask

  task automatic chk_sts(input string req, input int exp);
    rd(3'd0);
    check(req, rq, exp);
  endtask

  task automatic chk_burst(input string req, input int exp);
    logic [7:0] lo;
    rd(3'd2); lo = rq;
    rd(3'd3);
    check(req, {16'd0, rq, lo}, exp);
  endtask

  task automatic send_cmd(input int n, input int hl);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      case (i)
        2: b = hl[31:24];
        3: b = hl[23:16];
        4: b = hl[15:8];
        5: b = hl[7:0];
        default: b = 8'($urandom);
      endcase
      wr(3'd4, b);
    end
  endtask

  task automatic be_respond(input int n, input bit stest);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      case (i)
        2: b = 8'(n >> 24);
        3: b = 8'(n >> 16);
        4: b = 8'(n >> 8);
        5: b = 8'(n);
        default: b = 8'($urandom);
      endcase
      rbuf[i] = b;
      be_wr = 1; be_addr = 12'(i); be_wdata = b;
      @(negedge clk);
    end
    be_wr = 0; be_done = 1; be_selftest = stest;
    @(negedge clk);
    grab();
    be_done = 0; be_selftest = 0;
  endtask

  task automatic read_resp(input string req, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      rd(3'd4);
      check(req, rq, rbuf[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_sts("R1 reset status", 32'h01);
    chk_burst("R1 reset burst", DEPTH);
    rd(3'd4); check("R9 read without data", rq, 8'hFF);

    // R3 data write while idle dropped
    wr(3'd4, 8'h55);
    chk_sts("R3 idle data write status", 32'h01);
    chk_burst("R3 idle data write burst", DEPTH);

    // R2 command-ready
    wr(3'd0, 8'h40); check("R2 cmd-ready event", e_c, 1);
    chk_sts("R2 ready status", sts(0, 1, 0, 0));
    wr(3'd0, 8'h40); check("R2 no event in ready", e_c, 0);
    chk_sts("R2 ready unchanged", sts(0, 1, 0, 0));

    // R3 R4 reception with length 10
    wr(3'd4, 8'h80);
    chk_sts("R3 first byte status", sts(1, 0, 0, 1));
    wr(3'd4, 8'h01); wr(3'd4, 8'h00); wr(3'd4, 8'h00); wr(3'd4, 8'h00);
    chk_sts("R4 five bytes expect", sts(1, 0, 0, 1));
    wr(3'd4, 8'd10);
    chk_sts("R4 six of ten expect", sts(1, 0, 0, 1));
    wr(3'd4, 8'h11); wr(3'd4, 8'h22); wr(3'd4, 8'h33);
    wr(3'd0, 8'h20); check("R7 go with expect ignored", e_rq, 0);
    chk_sts("R7 go ignored status", sts(1, 0, 0, 1));
    wr(3'd4, 8'h44);
    chk_sts("R4 expect cleared at length", sts(1, 0, 0, 0));
    chk_burst("R11 free space", DEPTH - 10);
    wr(3'd4, 8'h99);
    chk_burst("R5 extra byte dropped", DEPTH - 10);
    wr(3'd0, 8'h20);
    check("R7 be_req", e_rq, 1);
    check("R7 be_len", be_len, 10);
    chk_sts("R7 exec status", sts(1, 0, 0, 0));
    wr(3'd4, 8'h77);
    chk_burst("R3 exec data write dropped", DEPTH - 10);

    // R8 completion with self-test
    be_respond(8, 1'b1);
    check("R8 valid event", e_v, 1);
    check("R8 data-avail event", e_d, 1);
    stk = 4;
    chk_sts("R8 completion status", sts(1, 0, 1, 0));
    chk_burst("R11 burst remaining", 8);
    rd(3'd1); check("R11 byte view", rq, 8);
    read_resp("R9 response byte", 0, 3);
    chk_burst("R11 burst after three", 5);
    wr(3'd0, 8'h02);
    chk_sts("R10 retry status", sts(1, 0, 1, 0));
    chk_burst("R10 retry burst", 8);
    read_resp("R10 replayed byte", 0, 7);
    rd(3'd4); check("R9 last byte", rq, rbuf[7]);
    check("R9 last byte event", e_v, 1);
    chk_sts("R9 data-avail cleared", sts(1, 0, 0, 0));
    rd(3'd4); check("R9 read past end", rq, 8'hFF);
    wr(3'd4, 8'h12);
    chk_burst("R3 completion data write dropped", DEPTH - 8);
    wr(3'd0, 8'h40); check("R12 cmd-ready event", e_c, 1);
    chk_sts("R12 ready with self-test kept", sts(0, 1, 0, 0));
    rd(3'd1); check("R11 byte view saturates", rq, 8'hFF);

    // R13 abort in reception
    send_cmd(3, 20);
    chk_sts("R13 receiving", sts(1, 0, 0, 1));
    wr(3'd0, 8'h40); check("R13 abort rx event", e_c, 1);
    chk_sts("R13 abort rx status", sts(0, 1, 0, 0));
    chk_burst("R13 abort rx count reset", DEPTH);

    // R13 abort in execution
    send_cmd(6, 6);
    wr(3'd0, 8'h20); check("R7 go", e_rq, 1);
    wr(3'd0, 8'h40);
    check("R13 cancel pulse", e_cn, 1);
    check("R13 no event yet", e_c, 0);
    chk_sts("R13 still executing", sts(1, 0, 0, 0));
    be_respond(6, 1'b0);
    check("R13 ready event after done", e_c, 1);
    check("R13 no data-avail event", e_d, 0);
    chk_sts("R13 abort exec status", sts(0, 1, 0, 0));

    // R6 overflow
    send_cmd(DEPTH, 5000);
    chk_sts("R6 full still expecting", sts(1, 0, 0, 1));
    chk_burst("R11 no free space", 0);
    wr(3'd4, 8'hAB);
    chk_sts("R6 overflow clears expect", sts(1, 0, 0, 0));
    wr(3'd0, 8'h20);
    check("R6 be_len full buffer", be_len, DEPTH);
    be_respond(6, 1'b0);
    chk_sts("R8 completion", sts(1, 0, 1, 0));
    wr(3'd0, 8'h40); check("R12 event with data pending", e_c, 1);
    chk_sts("R12 data-avail cleared", sts(0, 1, 0, 0));

    // random commands and responses
    for (int it = 0; it < 16; it++) begin
      int n, hl, m;
      if (it % 4 == 0) begin
        n = 6; hl = $urandom_range(0, 5);
      end else begin
        n = 6 + $urandom_range(0, 50); hl = n;
      end
      send_cmd(n, hl);
      chk_sts("R4 random command complete", sts(1, 0, 0, 0));
      wr(3'd0, 8'h20);
      check("R7 random be_req", e_rq, 1);
      check("R7 random be_len", be_len, n);
      m = 6 + $urandom_range(0, 300);
      be_respond(m, 1'b0);
      chk_burst("R11 random burst", m);
      rd(3'd1); check("R11 random byte view", rq, sat(m));
      read_resp("R9 random response", 0, m);
      chk_sts("R9 random drained", sts(1, 0, 0, 0));
      wr(3'd0, 8'h40); check("R12 random cmd-ready", e_c, 1);
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule